// File: doc/BRIEF.md
# Block-Granular Security Gate

This block decides, one transaction at a time, whether an access may pass to the memory behind it. The memory is cut into equal power-of-two blocks. Each block owns one bit of a lookup table that a separate register file holds and exports as a flat vector of 32-bit words. A set bit gives the block to the non-secure world, and a clear bit gives it to the secure world. A transaction passes only when its own world matches the bit of its block.

Each cycle the gate samples the transaction address, the secure attribute and the "attributes unspecified" flag. It registers a verdict, so the result shows one clock later. The outputs are a pass flag, the table bit that was consulted (for the fault-capture logic next to it) and a range flag. The verdict register is the state of the block and has four states:

- `VERD_IDLE`: the reset state.
- `VERD_PASS`: the access is allowed.
- `VERD_DENY_ATTR`: the world does not match the block's bit.
- `VERD_DENY_RANGE`: the address lies past the end of the memory.

Every clock edge moves the register to whichever verdict the current inputs select. A rising reset returns it to `VERD_IDLE`. A constant code reports the block size to software.

Top module: `sec_gate`

## Requirements
- R1: While `rst_n` is low, and until the first rising clock edge with `rst_n` high, `gate_pass`, `gate_in_range` and `gate_cfg_bit` are all 0.
- R2: The block number is `addr / BLK_BYTES`. The word holding its bit is the block number divided by 32, and the bit inside that word is the block number modulo 32. Word w occupies `lut_flat[32*w+31 : 32*w]`. For an in-range address, `gate_cfg_bit` reports that bit.
- R3: A transaction with `attr_secure`=1 passes only when its block's bit is 0.
- R4: A transaction with `attr_secure`=0 and `attr_unspec`=0 passes only when its block's bit is 1.
- R5: A transaction with `attr_unspec`=1 is judged as secure, whatever the value of `attr_secure`.
- R6: An address at or above `MEM_BYTES` never passes. It gives `gate_in_range`=0 and `gate_cfg_bit`=0, whatever the table holds.
- R7: The table holds ceil((MEM_BYTES/BLK_BYTES)/32) words. Bits beyond the last real block have no effect on any result.
- R8: Results appear exactly one cycle after the inputs are sampled. They use the table value present at that sampling edge, so a table change applies to the very next transaction.
- R9: `blk_size_code` equals log2(`BLK_BYTES`) minus 5. The smallest legal block size is 32 bytes.
- R10: With an all-zero table, as the register file holds after reset, secure traffic to any in-range address passes and non-secure traffic is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address of the transaction |
| attr_secure | input | 1 | 1 = secure transaction |
| attr_unspec | input | 1 | 1 = attributes not given; treated as secure |
| lut_flat | input | LUT_BITS | Block security table, word w at bits 32*w+31:32*w |
| gate_pass | output | 1 | Registered verdict: 1 = may pass downstream |
| gate_cfg_bit | output | 1 | Registered table bit of the addressed block |
| gate_in_range | output | 1 | Registered flag: address below MEM_BYTES |
| blk_size_code | output | 5 | log2(BLK_BYTES) - 5 |

## Verification
The assertions compare each registered result with the inputs one cycle earlier. They assume that `addr`, the attributes and `lut_flat` are steady around each rising edge. They also assume that the parameters describe a memory that is a whole number of power-of-two blocks of at least 32 bytes. The bench changes inputs only on falling edges and uses the default parameters. Its random addresses are drawn mostly below `MEM_BYTES` and partly across the rest of the address space, so both the in-range and the out-of-range paths are exercised under the same timing assumption.

// File: rtl/sgate_pkg.sv
package sgate_pkg;

    // Verdict register encoding; VERD_IDLE is the reset state.
    typedef enum logic [1:0] {
        VERD_IDLE       = 2'd0,
        VERD_PASS       = 2'd1,
        VERD_DENY_ATTR  = 2'd2,
        VERD_DENY_RANGE = 2'd3
    } verdict_e;

    localparam int unsigned TABLE_WORD_BITS = 32;
    localparam int unsigned MIN_BLK_SHIFT   = 5;

endpackage

// File: rtl/sgate_locate.sv
module sgate_locate #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned BLK_SHIFT = 8,
    parameter int unsigned MEM_BYTES = 10240,
    parameter int unsigned WORD_W    = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word_idx,
    output logic [4:0]        bit_idx,
    output logic              in_range
);
    localparam int unsigned BLK_NUM_W = ADDR_W - BLK_SHIFT;
    localparam logic [ADDR_W:0] MEM_LIMIT = (ADDR_W+1)'(MEM_BYTES);

    logic [BLK_NUM_W-1:0] blk_num;

    // R2: block number, then word and bit within the packed table
    assign blk_num  = addr[ADDR_W-1:BLK_SHIFT];
    assign word_idx = blk_num[BLK_NUM_W-1:5];
    assign bit_idx  = blk_num[4:0];

    // R6: anything at or past the end of memory is out of range
    assign in_range = ({1'b0, addr} < MEM_LIMIT);
endmodule

// File: rtl/sgate_lutsel.sv
module sgate_lutsel #(
    parameter int unsigned LUT_WORDS = 2,
    parameter int unsigned WORD_W    = 3
) (
    input  logic [LUT_WORDS*32-1:0] lut_flat,
    input  logic [WORD_W-1:0]       word_idx,
    input  logic [4:0]              bit_idx,
    output logic                    cfg_bit
);
    logic [31:0] words [LUT_WORDS];

    for (genvar g = 0; g < LUT_WORDS; g++) begin : g_word
        assign words[g] = lut_flat[g*32 +: 32];
    end

    always_comb begin
        cfg_bit = 1'b0;
        for (int w = 0; w < LUT_WORDS; w++) begin
            if (word_idx == WORD_W'(w)) begin
                cfg_bit = words[w][bit_idx];
            end
        end
    end
endmodule

// File: rtl/sgate_judge.sv
module sgate_judge
    import sgate_pkg::*;
(
    input  logic     in_range,
    input  logic     cfg_bit,
    input  logic     attr_secure,
    input  logic     attr_unspec,
    output verdict_e verdict
);
    logic eff_secure;

    // R5: missing attributes count as secure
    assign eff_secure = attr_secure | attr_unspec;

    always_comb begin
        if (!in_range) begin
            verdict = VERD_DENY_RANGE;
        end else if (cfg_bit != eff_secure) begin
            // R3/R4: bit 0 owns secure, bit 1 owns non-secure
            verdict = VERD_PASS;
        end else begin
            verdict = VERD_DENY_ATTR;
        end
    end
endmodule

// File: rtl/sec_gate.sv
module sec_gate
    import sgate_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned MEM_BYTES = 10240,
    parameter int unsigned BLK_BYTES = 256,
    localparam int unsigned BLK_SHIFT  = $clog2(BLK_BYTES),
    localparam int unsigned NUM_BLOCKS = MEM_BYTES / BLK_BYTES,
    localparam int unsigned LUT_WORDS  = (NUM_BLOCKS + TABLE_WORD_BITS - 1) / TABLE_WORD_BITS,
    localparam int unsigned LUT_BITS   = LUT_WORDS * TABLE_WORD_BITS,
    localparam int unsigned WORD_W     = ADDR_W - BLK_SHIFT - 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                attr_secure,
    input  logic                attr_unspec,
    input  logic [LUT_BITS-1:0] lut_flat,
    output logic                gate_pass,
    output logic                gate_cfg_bit,
    output logic                gate_in_range,
    output logic [4:0]          blk_size_code
);
    logic [WORD_W-1:0] word_idx;
    logic [4:0]        bit_idx;
    logic              in_range;
    logic              cfg_bit;
    verdict_e          verdict_d;
    verdict_e          verdict_q;
    logic              cfg_q;

    sgate_locate #(
        .ADDR_W   (ADDR_W),
        .BLK_SHIFT(BLK_SHIFT),
        .MEM_BYTES(MEM_BYTES),
        .WORD_W   (WORD_W)
    ) u_locate (
        .addr    (addr),
        .word_idx(word_idx),
        .bit_idx (bit_idx),
        .in_range(in_range)
    );

    sgate_lutsel #(
        .LUT_WORDS(LUT_WORDS),
        .WORD_W   (WORD_W)
    ) u_lutsel (
        .lut_flat(lut_flat),
        .word_idx(word_idx),
        .bit_idx (bit_idx),
        .cfg_bit (cfg_bit)
    );

    sgate_judge u_judge (
        .in_range   (in_range),
        .cfg_bit    (cfg_bit),
        .attr_secure(attr_secure),
        .attr_unspec(attr_unspec),
        .verdict    (verdict_d)
    );

    // R9: constant block size code
    assign blk_size_code = 5'(BLK_SHIFT - MIN_BLK_SHIFT);

    // State register: R1 reset, R8 one-cycle latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_q <= VERD_IDLE;
            cfg_q     <= 1'b0;
        end else begin
            verdict_q <= verdict_d;
            cfg_q     <= in_range & cfg_bit;
        end
    end

    // Output decode from the verdict state
    always_comb begin
        gate_cfg_bit = cfg_q;
        unique case (verdict_q)
            VERD_IDLE: begin
                gate_pass     = 1'b0;
                gate_in_range = 1'b0;
            end
            VERD_PASS: begin
                gate_pass     = 1'b1;
                gate_in_range = 1'b1;
            end
            VERD_DENY_ATTR: begin
                gate_pass     = 1'b0;
                gate_in_range = 1'b1;
            end
            VERD_DENY_RANGE: begin
                gate_pass     = 1'b0;
                gate_in_range = 1'b0;
            end
            default: begin
                gate_pass     = 1'b0;
                gate_in_range = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sgate_checker.sv
module sgate_checker #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned MEM_BYTES = 10240
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              attr_secure,
    input logic              attr_unspec,
    input logic              gate_pass,
    input logic              gate_cfg_bit,
    input logic              gate_in_range
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

    // R6: past end of memory gives a blocked, bit-free result
    a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, $past(addr)} >= LIMIT) |-> (!gate_in_range && !gate_pass && !gate_cfg_bit));

    // R6: a pass always lies inside memory
    a_r6_pass_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        gate_pass |-> gate_in_range);

    // R3 and R4: a pass means the reported bit opposes the effective world
    a_r4_world_match: assert property (@(posedge clk) disable iff (!rst_n)
        gate_pass |-> (gate_cfg_bit != ($past(attr_secure) | $past(attr_unspec))));

    // R5: an unspecified access only passes through secure-owned blocks
    a_r5_unspec_secure: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_pass && $past(attr_unspec)) |-> !gate_cfg_bit);
endmodule

bind sec_gate sgate_checker #(
    .ADDR_W   (ADDR_W),
    .MEM_BYTES(MEM_BYTES)
) u_sgate_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .attr_secure  (attr_secure),
    .attr_unspec  (attr_unspec),
    .gate_pass    (gate_pass),
    .gate_cfg_bit (gate_cfg_bit),
    .gate_in_range(gate_in_range)
);

// File: tb/tb_sec_gate.sv
module tb_sec_gate;
    localparam int ADDR_W    = 16;
    localparam int MEM_BYTES = 10240;
    localparam int BLK_BYTES = 256;
    localparam int LUT_BITS  = 64;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [ADDR_W-1:0]   addr = '0;
    logic                attr_secure = 1'b1;
    logic                attr_unspec = 1'b0;
    logic [LUT_BITS-1:0] lut_flat = '0;
    logic                gate_pass;
    logic                gate_cfg_bit;
    logic                gate_in_range;
    logic [4:0]          blk_size_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sec_gate #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .BLK_BYTES(BLK_BYTES)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .attr_secure(attr_secure),
        .attr_unspec(attr_unspec), .lut_flat(lut_flat), .gate_pass(gate_pass),
        .gate_cfg_bit(gate_cfg_bit), .gate_in_range(gate_in_range),
        .blk_size_code(blk_size_code)
    );

    // Expected {pass, cfg_bit, in_range} from the requirements
    function automatic logic [2:0] model(input logic [ADDR_W-1:0] a, input logic s,
                                         input logic u, input logic [LUT_BITS-1:0] l);
        int blk;
        int wrd;
        int bt;
        logic bitv;
        logic sec;
        if (int'(a) >= MEM_BYTES) return 3'b000;
        blk  = int'(a) / BLK_BYTES;
        wrd  = blk / 32;
        bt   = blk % 32;
        bitv = l[wrd*32 + bt];
        sec  = s | u;
        return {(sec ? !bitv : bitv), bitv, 1'b1};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge: drive, wait one cycle, compare
    task automatic txn(input string req, input logic [ADDR_W-1:0] a, input logic s,
                       input logic u, input logic [LUT_BITS-1:0] l);
        logic [2:0] e;
        addr = a; attr_secure = s; attr_unspec = u; lut_flat = l;
        e = model(a, s, u, l);
        @(negedge clk);
        check(req, {29'd0, gate_pass, gate_cfg_bit, gate_in_range}, {29'd0, e});
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [LUT_BITS-1:0] l;
        int seed;
        seed = $urandom(32'h5EC6A7E);
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 reset", {29'd0, gate_pass, gate_cfg_bit, gate_in_range}, 32'd0);
        // R9: size code for 256-byte blocks is 8-5
        check("R9 size code", {27'd0, blk_size_code}, 32'd3);
        rst_n = 1'b1;
        check("R1 after release", {29'd0, gate_pass, gate_cfg_bit, gate_in_range}, 32'd0);

        // R10: all-zero table
        txn("R10 secure zero table", 16'h0000, 1'b1, 1'b0, '0);
        txn("R10 nonsecure zero table", 16'h1234, 1'b0, 1'b0, '0);
        // R2/R4: block 33 is word 1 bit 1
        l = '0; l[33] = 1'b1;
        txn("R2 R4 nonsecure block33", 16'(33*256 + 5), 1'b0, 1'b0, l);
        txn("R3 secure block33", 16'(33*256 + 255), 1'b1, 1'b0, l);
        txn("R2 block32 neighbour", 16'(32*256), 1'b0, 1'b0, l);
        txn("R2 block31 word0", 16'(31*256 + 7), 1'b1, 1'b0, l);
        // R5: unspecified counts as secure
        txn("R5 unspec clear bit", 16'(32*256), 1'b0, 1'b1, l);
        txn("R5 unspec set bit", 16'(33*256), 1'b0, 1'b1, l);
        // R6: out of range
        txn("R6 first beyond end", 16'(MEM_BYTES), 1'b1, 1'b0, '0);
        txn("R6 top address", 16'hFFFF, 1'b0, 1'b0, '1);
        // R7: padding bits have no effect; last real block
        l = '0; l[63:40] = '1;
        txn("R7 padding ignored", 16'(40*256), 1'b0, 1'b0, l);
        txn("R7 last block secure", 16'(39*256 + 255), 1'b1, 1'b0, l);
        l = '1;
        txn("R7 last block nonsecure", 16'(39*256 + 255), 1'b0, 1'b0, l);
        // R8: table change applies to the next transaction
        txn("R8 before update", 16'(3*256), 1'b1, 1'b0, '0);
        l = '0; l[3] = 1'b1;
        txn("R8 after update", 16'(3*256), 1'b1, 1'b0, l);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] a;
            l = {$urandom, $urandom};
            if (($urandom % 8) == 0) a = 16'($urandom);
            else a = 16'($urandom % MEM_BYTES);
            txn("R2 R3 R4 R5 R6 random", a, 1'($urandom), 1'(($urandom % 4) == 0), l);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule